// File: doc/BRIEF.md
# NAND Read-Cache Pipeline Emulator

This block is a cycle-counted model of the device side of a NAND flash read path with a two-stage page pipeline. A byte-wide bus carries commands and address bytes, each marked by its own one-cycle strobe. A read strobe steps through the bytes of the page held in the cache register. Behind the cache register sits a data register that is filled from a small on-chip array. An array fetch takes a programmable number of cycles, so the fetch of the next page can run while the host drains the current one.

A plain page read opens a page at a chosen column. The continue-cache command then hands the data register to the cache register and starts the fetch of the following page in the background. The end-cache command hands over the last fetched page without starting another fetch. While the read-cache mode is active, commands are filtered. A status command reports cache readiness and array readiness. A soft reset command aborts everything. The array contents come from a fixed formula, so a host model can predict every byte it reads.

Top module: `nand_cache_read_emu`

## Requirements
- R1: The sequence 00h, a column address byte, a page address byte, 30h (each on `io_in` with `cmd_we` or `addr_we`) makes `ready` low, fetches the page and then shows the byte at that column on `io_out`. Only the low address bits are used. Each `rd_en` pulse moves to the next column, and the last column is followed by column 0. Array byte (p,c) equals ((p*PAGE_BYTES + c) mod 256) XOR A5h.
- R2: 31h copies the data register into the cache register, sets the column to 0, enters read-cache mode and starts the fetch of the following page. When no fetch is pending, `ready` is low for no more than T_XFER cycles, and the new fetch then runs while `ready` is high.
- R3: A 31h given while a fetch is still pending keeps `ready` low until that fetch has completed and the transfer has finished. Given right after the previous 31h, it is busy for at least T_ARRAY cycles.
- R4: 3Fh in read-cache mode copies the data register into the cache register (column 0) and launches no fetch, so status bit 5 is 1 as soon as `ready` returns. It also leaves read-cache mode, and 30h is accepted again afterwards.
- R5: In read-cache mode only 00h, 31h, 3Fh, 70h and FFh are accepted. Any other command (for example 30h) and any address byte leaves `ready`, the output and the page sequence unchanged. While busy, only 70h and FFh are accepted.
- R6: After 70h, `io_out` shows a status byte. Bit 6 is 1 when `ready` is high. Bit 5 is 1 when `ready` is high and no array fetch is pending. All other bits are 0.
- R7: After 70h, `rd_en` keeps returning the status byte and does not move the column until another command is accepted. A following 00h shows page data again at the column where it stood.
- R8: FFh is accepted in any state. It makes `ready` high at the next edge, cancels any fetch (status reads 60h), leaves read-cache mode and sets the column to 0.
- R9: A following-page fetch launched from the last page targets page 0 and sets `wrap_flag`. The flag stays set until `rst_n` is low.
- R10: While `rst_n` is low at a clock edge, the block returns to `ready` high, `wrap_flag` low, read-cache mode off and `io_out` 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | One-cycle strobe: `io_in` carries a command |
| addr_we | input | 1 | One-cycle strobe: `io_in` carries an address byte |
| rd_en | input | 1 | One-cycle read strobe, advances the column |
| io_in | input | 8 | Command or address byte |
| io_out | output | 8 | Page byte at the current column, or the status byte |
| ready | output | 1 | High when the block accepts ordinary commands |
| wrap_flag | output | 1 | Sticky: a fetch has wrapped past the last page |

## Verification
A table of plain page reads at different pages and columns, including the last column of the last page, separates correct address capture and column wrap from a fixed or off-by-one column. Back-to-back 31h commands are given both after the background fetch has finished and immediately after the previous one. The busy lengths measured in each case tell a transfer that waits for the array from one that does not. Commands that should be dropped in read-cache mode, status reads during a pending fetch, 3Fh, FFh in mid-fetch and a fetch past the last page each leave a visible mark on `io_out`, `ready` or `wrap_flag` that a wrong filter or pipeline would change.

// File: rtl/nand_rc_pkg.sv
// Shared definitions for the NAND read-cache emulator: command codes,
// controller state type and the array fill formula.
// Assumes byte-wide commands; the fill formula is the only array content.
package nand_rc_pkg;

    localparam logic [7:0] OP_READ    = 8'h00;
    localparam logic [7:0] OP_CONFIRM = 8'h30;
    localparam logic [7:0] OP_CONT    = 8'h31;
    localparam logic [7:0] OP_END     = 8'h3F;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_RESET   = 8'hFF;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,   // idle, output available
        ST_FETCH = 2'd1,   // foreground fetch for a plain page read
        ST_WAIT  = 2'd2,   // waiting for a background fetch to finish
        ST_XFER  = 2'd3    // data register to cache register transfer
    } rc_state_t;

    // Array byte at (page, column): low byte of the linear index, XOR A5h.
    function automatic logic [7:0] fill_byte(input int unsigned page,
                                             input int unsigned col,
                                             input int unsigned page_bytes);
        return 8'(page * page_bytes + col) ^ 8'hA5;
    endfunction

endpackage

// File: rtl/nand_rc_array.sv
// Read-only page array. Returns a whole page for the selected page index.
// Assumes the contents follow nand_rc_pkg::fill_byte; purely combinational.
module nand_rc_array
    import nand_rc_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int PAGE_W     = 3
) (
    input  logic [PAGE_W-1:0]       page,
    output logic [PAGE_BYTES*8-1:0] data
);

    // One byte lane per column, each computed from the fill formula.
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
        assign data[b*8 +: 8] = fill_byte(32'(page), b, PAGE_BYTES);
    end

endmodule

// File: rtl/nand_rc_fetch.sv
// Array fetch engine with the data register. A start pulse begins a fetch
// of T_ARRAY cycles; on completion the page lands in the data register.
// Assumes start is never raised while a fetch is active; abort wins.
module nand_rc_fetch #(
    parameter int PAGE_BYTES = 16,
    parameter int PAGE_W     = 3,
    parameter int T_ARRAY    = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    abort,
    input  logic [PAGE_W-1:0]       start_page,
    input  logic [PAGE_BYTES*8-1:0] arr_data,
    output logic [PAGE_W-1:0]       arr_page,
    output logic                    active,
    output logic                    done,
    output logic [PAGE_BYTES*8-1:0] dr_data,
    output logic [PAGE_W-1:0]       dr_page
);

    localparam int             CW       = $clog2(T_ARRAY + 1);
    localparam logic [CW-1:0]  CNT_LOAD = CW'(T_ARRAY);

    logic [CW-1:0]     cnt_q;
    logic [PAGE_W-1:0] pend_q;

    assign arr_page = pend_q;
    assign done     = active && (cnt_q == CW'(1));

    // Fetch timer: load on start, count down, capture the page on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt_q   <= '0;
            pend_q  <= '0;
            dr_data <= '0;
            dr_page <= '0;
        end else if (abort) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt_q  <= CNT_LOAD;
            pend_q <= start_page;
        end else if (active) begin
            if (done) begin
                active  <= 1'b0;
                dr_data <= arr_data;
                dr_page <= pend_q;
            end
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/nand_rc_cache.sv
// Cache register with the column counter and the output selector.
// Assumes load and col_load come from the controller on the same edge.
module nand_rc_cache #(
    parameter int PAGE_BYTES = 16,
    parameter int COL_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [PAGE_BYTES*8-1:0] load_data,
    input  logic                    col_load,
    input  logic [COL_W-1:0]        col_val,
    input  logic                    advance,
    input  logic                    status_sel,
    input  logic [7:0]              status_byte,
    output logic [COL_W-1:0]        col,
    output logic [7:0]              io_out
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

    logic [7:0] cache_q [PAGE_BYTES];

    // Cache register: take the whole data register on a transfer.
    always_ff @(posedge clk) begin
        for (int b = 0; b < PAGE_BYTES; b++) begin
            if (!rst_n)    cache_q[b] <= '0;
            else if (load) cache_q[b] <= load_data[b*8 +: 8];
        end
    end

    // Column counter: set by the controller, else step on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        col <= '0;
        else if (col_load) col <= col_val;
        else if (advance)  col <= (col == LAST_COL) ? '0 : col + 1'b1;
    end

    // Output selector: status byte or page byte at the column.
    always_comb begin
        io_out = status_sel ? status_byte : cache_q[col];
    end

endmodule

// File: rtl/nand_rc_ctrl.sv
// Command decoder and pipeline controller. Filters commands by mode and
// busy state, sequences fetch, wait and transfer, keeps the status mode
// and the sticky wrap flag. Assumes single-cycle strobes, one per cycle.
module nand_rc_ctrl
    import nand_rc_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int T_XFER    = 4,
    parameter int COL_W     = 4,
    parameter int PAGE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              addr_we,
    input  logic              rd_en,
    input  logic [7:0]        io_in,
    input  logic              fetch_active,
    input  logic              fetch_done,
    input  logic [PAGE_W-1:0] dr_page,
    output logic              fetch_start,
    output logic              fetch_abort,
    output logic [PAGE_W-1:0] fetch_page,
    output logic              cache_load,
    output logic              col_load,
    output logic [COL_W-1:0]  col_val,
    output logic              rd_advance,
    output logic              status_sel,
    output logic [7:0]        status_byte,
    output logic              ready,
    output logic              cache_mode,
    output logic              xfer_launch,
    output logic              wrap_flag
);

    localparam int              XW        = $clog2(T_XFER + 1);
    localparam logic [XW-1:0]   XFER_LOAD = XW'(T_XFER);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

    rc_state_t         state_q;
    logic [XW-1:0]     xcnt_q;
    logic [COL_W-1:0]  col_after_q;
    logic [COL_W-1:0]  addr_col_q;
    logic [PAGE_W-1:0] addr_page_q;
    logic [1:0]        addr_idx_q;
    logic              status_q;
    logic              do_read, do_confirm, do_cont, do_end, do_status, do_reset;
    logic              other_cmd, xfer_end, pending;
    logic [PAGE_W-1:0] next_page;

    assign ready      = (state_q == ST_READY);
    assign pending    = fetch_active && !fetch_done;
    assign xfer_end   = (state_q == ST_XFER) && (xcnt_q == XW'(1));
    assign next_page  = (dr_page == LAST_PAGE) ? '0 : dr_page + 1'b1;
    assign other_cmd  = do_read || do_confirm || do_cont || do_end;

    // Command filter: status and reset always; the rest only when ready and allowed by mode.
    always_comb begin
        do_read    = 1'b0;
        do_confirm = 1'b0;
        do_cont    = 1'b0;
        do_end     = 1'b0;
        do_status  = 1'b0;
        do_reset   = 1'b0;
        if (cmd_we) begin
            if (io_in == OP_STATUS)                  do_status  = 1'b1;
            else if (io_in == OP_RESET)              do_reset   = 1'b1;
            else if (ready) begin
                if (io_in == OP_READ)                do_read    = 1'b1;
                else if (io_in == OP_CONT)           do_cont    = 1'b1;
                else if (io_in == OP_END && cache_mode)     do_end     = 1'b1;
                else if (io_in == OP_CONFIRM && !cache_mode) do_confirm = 1'b1;
            end
        end
    end

    // Datapath strobes toward the fetch engine and the cache register.
    always_comb begin
        fetch_start = do_confirm || (xfer_end && xfer_launch && !do_reset);
        fetch_page  = do_confirm ? addr_page_q : next_page;
        fetch_abort = do_reset;
        cache_load  = xfer_end && !do_reset;
        col_load    = xfer_end || do_reset;
        col_val     = do_reset ? '0 : col_after_q;
        rd_advance  = rd_en && ready && !status_q;
        status_sel  = status_q;
        status_byte = {1'b0, ready, ready && !fetch_active, 5'b0};
    end

    // Sequencer: state, transfer timer, mode bits and address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_READY;
            xcnt_q      <= '0;
            xfer_launch <= 1'b0;
            col_after_q <= '0;
            addr_col_q  <= '0;
            addr_page_q <= '0;
            addr_idx_q  <= 2'd2;
            status_q    <= 1'b0;
            cache_mode  <= 1'b0;
        end else if (do_reset) begin
            state_q     <= ST_READY;
            xfer_launch <= 1'b0;
            addr_idx_q  <= 2'd2;
            status_q    <= 1'b0;
            cache_mode  <= 1'b0;
        end else begin
            if (do_status)      status_q <= 1'b1;
            else if (other_cmd) status_q <= 1'b0;
            case (state_q)
                ST_READY: begin
                    if (do_read && !cache_mode) addr_idx_q <= 2'd0;
                    if (do_confirm) begin
                        state_q     <= ST_FETCH;
                        col_after_q <= addr_col_q;
                        xfer_launch <= 1'b0;
                    end else if (do_cont || do_end) begin
                        state_q     <= pending ? ST_WAIT : ST_XFER;
                        xcnt_q      <= XFER_LOAD;
                        col_after_q <= '0;
                        xfer_launch <= do_cont;
                        cache_mode  <= do_cont;
                    end
                    if (addr_we && !cache_mode) begin
                        if (addr_idx_q == 2'd0) begin
                            addr_col_q <= io_in[COL_W-1:0];
                            addr_idx_q <= 2'd1;
                        end else if (addr_idx_q == 2'd1) begin
                            addr_page_q <= io_in[PAGE_W-1:0];
                            addr_idx_q  <= 2'd2;
                        end
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        state_q <= ST_XFER;
                        xcnt_q  <= XFER_LOAD;
                    end
                end
                ST_WAIT: begin
                    if (fetch_done || !fetch_active) begin
                        state_q <= ST_XFER;
                        xcnt_q  <= XFER_LOAD;
                    end
                end
                ST_XFER: begin
                    if (xfer_end) state_q <= ST_READY;
                    xcnt_q <= xcnt_q - 1'b1;
                end
                default: state_q <= ST_READY;
            endcase
        end
    end

    // Sticky wrap flag: set when the following-page fetch starts from the last page.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wrap_flag <= 1'b0;
        else if (xfer_end && xfer_launch && !do_reset && dr_page == LAST_PAGE)
            wrap_flag <= 1'b1;
    end

endmodule

// File: rtl/nand_cache_read_emu.sv
// Top of the NAND read-cache pipeline emulator: controller, fetch engine
// with data register, page array and cache register with output selector.
// Assumes PAGE_BYTES and NUM_PAGES are powers of two, at least 2 and at most 256.
module nand_cache_read_emu #(
    parameter int PAGE_BYTES = 16,
    parameter int NUM_PAGES  = 8,
    parameter int T_ARRAY    = 40,
    parameter int T_XFER     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic       addr_we,
    input  logic       rd_en,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       ready,
    output logic       wrap_flag
);

    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = $clog2(NUM_PAGES);

    logic                    fetch_start, fetch_abort, fetch_active, fetch_done;
    logic [PAGE_W-1:0]       fetch_page, arr_page, dr_page;
    logic [PAGE_BYTES*8-1:0] arr_data, dr_data;
    logic                    cache_load, col_load, rd_advance, status_sel;
    logic                    cache_mode, xfer_launch;
    logic [COL_W-1:0]        col_val, cur_col;
    logic [7:0]              status_byte;

    nand_rc_ctrl #(
        .NUM_PAGES(NUM_PAGES), .T_XFER(T_XFER), .COL_W(COL_W), .PAGE_W(PAGE_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .addr_we(addr_we),
        .rd_en(rd_en), .io_in(io_in), .fetch_active(fetch_active),
        .fetch_done(fetch_done), .dr_page(dr_page), .fetch_start(fetch_start),
        .fetch_abort(fetch_abort), .fetch_page(fetch_page),
        .cache_load(cache_load), .col_load(col_load), .col_val(col_val),
        .rd_advance(rd_advance), .status_sel(status_sel),
        .status_byte(status_byte), .ready(ready), .cache_mode(cache_mode),
        .xfer_launch(xfer_launch), .wrap_flag(wrap_flag)
    );

    nand_rc_fetch #(
        .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .T_ARRAY(T_ARRAY)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(fetch_start), .abort(fetch_abort),
        .start_page(fetch_page), .arr_data(arr_data), .arr_page(arr_page),
        .active(fetch_active), .done(fetch_done), .dr_data(dr_data),
        .dr_page(dr_page)
    );

    nand_rc_array #(
        .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W)
    ) u_array (
        .page(arr_page), .data(arr_data)
    );

    nand_rc_cache #(
        .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)
    ) u_cache (
        .clk(clk), .rst_n(rst_n), .load(cache_load), .load_data(dr_data),
        .col_load(col_load), .col_val(col_val), .advance(rd_advance),
        .status_sel(status_sel), .status_byte(status_byte), .col(cur_col),
        .io_out(io_out)
    );

endmodule

// File: rtl/nand_cache_read_emu_chk.sv
// Property checker for the read-cache emulator, bound into the top module.
// Assumes the internal names of nand_cache_read_emu.
module nand_cache_read_emu_chk #(
    parameter int COL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic             rd_en,
    input logic [7:0]       io_in,
    input logic             ready,
    input logic             wrap_flag,
    input logic             cache_mode,
    input logic             cache_load,
    input logic             xfer_launch,
    input logic             fetch_active,
    input logic             status_sel,
    input logic [COL_W-1:0] cur_col
);

    // R2: a continue transfer is followed by a running fetch.
    a_r2_launch_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_load && xfer_launch && !(cmd_we && io_in == 8'hFF)) |=> fetch_active);

    // R3: the cache register is never overwritten while the array is still fetching.
    a_r3_no_xfer_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        cache_load |-> !fetch_active);

    // R4: an end transfer launches no fetch.
    a_r4_end_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_load && !xfer_launch) |=> !fetch_active);

    // R5: a page-read confirm in read-cache mode does not make the block busy.
    a_r5_filter_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_mode && ready && cmd_we && io_in == 8'h30) |=> ready);

    // R7: read strobes in status mode leave the column alone.
    a_r7_status_holds_col: assert property (@(posedge clk) disable iff (!rst_n)
        (status_sel && rd_en && !cmd_we && !cache_load) |=> $stable(cur_col));

    // R8: soft reset makes the block ready and leaves read-cache mode.
    a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && io_in == 8'hFF) |=> (ready && !cache_mode));

    // R9: the wrap flag never clears without rst_n.
    a_r9_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_flag |=> wrap_flag);

endmodule

bind nand_cache_read_emu nand_cache_read_emu_chk #(.COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .rd_en(rd_en), .io_in(io_in),
    .ready(ready), .wrap_flag(wrap_flag), .cache_mode(cache_mode),
    .cache_load(cache_load), .xfer_launch(xfer_launch),
    .fetch_active(fetch_active), .status_sel(status_sel), .cur_col(cur_col)
);

// File: tb/nand_cache_read_emu_tb.sv
`timescale 1ns/1ps
module nand_cache_read_emu_tb;

    localparam int PB      = 16;
    localparam int T_ARRAY = 40;
    localparam int T_XFER  = 4;

    // {page, column, expected first byte}
    localparam logic [23:0] VEC [5] = '{
        24'h00_00_A5, 24'h03_05_90, 24'h07_0F_DA, 24'h02_09_8C, 24'h05_00_F5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0, addr_we = 1'b0, rd_en = 1'b0;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic       ready, wrap_flag;
    int         checks = 0, fails = 0;

    nand_cache_read_emu #(.PAGE_BYTES(PB), .NUM_PAGES(8), .T_ARRAY(T_ARRAY),
                          .T_XFER(T_XFER)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .addr_we(addr_we),
        .rd_en(rd_en), .io_in(io_in), .io_out(io_out), .ready(ready),
        .wrap_flag(wrap_flag)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input int p, input int c);
        return 8'(p * PB + (c % PB)) ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_we = 1'b1; io_in = b;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic send_addr(input logic [7:0] b);
        addr_we = 1'b1; io_in = b;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic pulse_rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic open_page(input int p, input int c);
        int n;
        send_cmd(8'h00);
        send_addr(8'(c));
        send_addr(8'(p));
        send_cmd(8'h30);
        wait_ready(n);
    endtask

    task automatic wait_array();
        int g = 0;
        send_cmd(8'h70);
        while (io_out !== 8'h60 && g < 5000) begin
            @(negedge clk);
            g++;
        end
        send_cmd(8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", ready, 1);
        chk("R10 wrap after reset", wrap_flag, 0);
        chk("R10 io_out after reset", io_out, 8'h00);
        send_cmd(8'h70);
        chk("R6 idle status", io_out, 8'h60);
        pulse_rd();
        chk("R7 status repeats", io_out, 8'h60);

        // R1: plain page reads from the vector table
        for (int i = 0; i < 5; i++) begin
            int p, c;
            p = int'(VEC[i][23:16]);
            c = int'(VEC[i][15:8]);
            open_page(p, c);
            chk("R1 first byte", io_out, int'(VEC[i][7:0]));
            pulse_rd();
            chk("R1 next byte", io_out, pat(p, c + 1));
        end

        // R2: continue after a plain read, no fetch pending
        open_page(2, 3);
        send_cmd(8'h31);
        wait_ready(n);
        chk("R2 short busy", int'(n <= T_XFER), 1);
        chk("R2 column 0 of data register page", io_out, pat(2, 0));
        send_cmd(8'h70);
        chk("R6 fetch pending status", io_out, 8'h40);
        pulse_rd();
        chk("R7 strobe keeps status", io_out, 8'h40);
        send_cmd(8'h00);
        chk("R7 column unchanged after status", io_out, pat(2, 0));
        for (int c = 0; c < PB; c++) begin
            chk("R1 stream byte", io_out, pat(2, c));
            pulse_rd();
        end
        wait_array();
        send_cmd(8'h31);
        wait_ready(n);
        chk("R2 short busy after fetch done", int'(n <= T_XFER), 1);
        chk("R2 following page", io_out, pat(3, 0));

        // R3: continue right after the previous one
        send_cmd(8'h31);
        wait_ready(n);
        chk("R3 long busy", int'(n >= T_ARRAY), 1);
        chk("R3 next page", io_out, pat(4, 0));

        // R5: filtered commands in read-cache mode
        pulse_rd();
        pulse_rd();
        send_cmd(8'h30);
        chk("R5 confirm ignored ready", ready, 1);
        chk("R5 confirm ignored output", io_out, pat(4, 2));
        send_addr(8'h07);
        send_cmd(8'h80);
        chk("R5 address and 80h ignored", io_out, pat(4, 2));
        wait_array();
        send_cmd(8'h31);
        wait_ready(n);
        chk("R5 page sequence kept", io_out, pat(5, 0));

        // R4: end command while the fetch of page 6 is pending
        send_cmd(8'h3F);
        wait_ready(n);
        chk("R4 end waits for fetch", int'(n >= T_ARRAY), 1);
        chk("R4 last page delivered", io_out, pat(6, 0));
        send_cmd(8'h70);
        chk("R4 no new fetch", io_out, 8'h60);
        open_page(1, 4);
        chk("R4 plain read accepted after end", io_out, pat(1, 4));

        // R9: wrap past the last page
        open_page(7, 0);
        chk("R9 no wrap yet", wrap_flag, 0);
        send_cmd(8'h31);
        wait_ready(n);
        chk("R9 last page in cache", io_out, pat(7, 0));
        chk("R9 wrap set", wrap_flag, 1);
        wait_array();
        send_cmd(8'h31);
        wait_ready(n);
        chk("R9 page 0 follows", io_out, pat(0, 0));

        // R8: soft reset
        pulse_rd();
        pulse_rd();
        pulse_rd();
        send_cmd(8'hFF);
        chk("R8 column back to 0", io_out, pat(0, 0));
        chk("R9 wrap survives soft reset", wrap_flag, 1);
        send_cmd(8'h00);
        send_addr(8'h02);
        send_addr(8'h06);
        send_cmd(8'h30);
        chk("R1 busy during fetch", ready, 0);
        send_cmd(8'hFF);
        chk("R8 ready at once", ready, 1);
        send_cmd(8'h70);
        chk("R8 fetch cancelled", io_out, 8'h60);
        open_page(3, 1);
        chk("R8 normal mode after reset", io_out, pat(3, 1));

        // R10: hardware reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 wrap cleared", wrap_flag, 0);
        chk("R10 output cleared", io_out, 8'h00);
        chk("R10 ready", ready, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule